// File: doc/BRIEF.md
# BCD Time-of-Day Clock with Periodic Heartbeat Interrupt

This block keeps wall-clock time and a calendar date as packed BCD bytes. A single-cycle timebase pulse, nominally 32768 Hz, drives a prescaler. The prescaler produces one step per second. That step ripples through seconds, minutes, hours, day of month, month and a two-digit year. The calendar covers a 100-year span and gives February a 29th day when the year is a multiple of four. A separate weekday counter advances with every date change. Hours run either in 24-hour form or in 12-hour form with a PM marker. A run/stop control freezes timekeeping, and software can still load new values while it is frozen.

Alongside the clock, a free-running divider raises a periodic flag at one of fifteen power-of-two rates. The slowest rate is one event every half second and the fastest is one event per timebase pulse. Software enables the flag onto an active-low interrupt line and uses it as the processor's heartbeat. Software reaches everything through a sixteen-slot byte register window. The window has a 4-bit offset, a select, and one-cycle read and write strobes.

Top module: `rtc_heartbeat`

## Requirements
- R1: After reset the time reads 00:00:00 in 24-hour form, the date reads day 01, month 01, year 00, weekday 01, the control register (offset Eh) reads 02h, the rate and enable registers read 00h, and irqN is high.
- R2: The seconds counter advances once every TICKS_PER_SEC timebase pulses. Seconds and minutes (offsets 0h and 2h) wrap from 59h to 00h, and each wrap carries into the next field.
- R3: With control bit 1 set (24-hour form), hours (offset 4h) count 00h to 23h. The 23h-to-00h wrap advances the date.
- R4: With control bit 1 clear, hours bits 4:0 count 12h, 01h, 02h and so on up to 11h. Bit 7 is a PM marker that inverts on the 11h-to-12h step. The date advances only when 11h PM steps to 12h AM.
- R5: Day of month (offset 6h) wraps to 01h after 28h/29h, 30h or 31h as the month requires. February reaches 29h exactly when the BCD year is divisible by four.
- R6: Month (offset 9h) wraps from 12h to 01h and advances the year (offset Ah). The year wraps from 99h to 00h. Weekday (offset 8h) steps 1 to 7 and returns to 1 on each date change.
- R7: While control bit 2 is set, the prescaler and all time fields hold still. Bus writes to time fields still land.
- R8: The low nibble of offset Bh selects the heartbeat rate. Code n from 1 to 15 sets flag bit 1 of offset Dh once every 2^(n-1) timebase pulses. Code 0 never sets it.
- R9: A read of offset Dh returns the flag in bit 1 and clears it. A new event in the same cycle wins over the clear.
- R10: irqN is low exactly while the flag is set and enable bit 1 of offset Ch is 1.
- R11: Slots 1h, 3h, 5h and 7h, the high nibble of Bh, and the other bits of Ch and Eh read back as written and have no effect. Writes to Dh are ignored, and offset Fh reads 00h.
- R12: A read strobe with select high presents the addressed byte on rdata from the next clock cycle. rdata holds that byte until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle timebase pulse (nominally 32768 Hz) |
| cs | input | 1 | Register window select |
| rd | input | 1 | Read strobe, one cycle |
| wr | input | 1 | Write strobe, one cycle |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irqN | output | 1 | Active-low heartbeat interrupt |

## Verification
Assertions watch the local rules on every cycle. They check the 59-to-00 seconds wrap, the weekday return from 7 to 1, the PM inversion at the 11-to-12 hour step, and that the time fields and prescaler hold still whenever no step or write arrives. They also check the clear-on-read of the flag, that rate code 0 stays silent, and that the interrupt line only falls after a heartbeat event or an enable write. Only the bench scenarios can show the multi-field carry chains, such as end of year, leap and non-leap February ends, and midnight and noon in 12-hour form. The same holds for the exact spacing of heartbeat events, and for agreement between a bench calendar model and the design across randomly seeded starting dates.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  // Register window offsets. Time fields sit on the even slots below 8h;
  // the odd slots below 8h are plain storage bytes.
  localparam logic [3:0] OFF_SEC   = 4'h0;
  localparam logic [3:0] OFF_MIN   = 4'h2;
  localparam logic [3:0] OFF_HOUR  = 4'h4;
  localparam logic [3:0] OFF_DAY   = 4'h6;
  localparam logic [3:0] OFF_WDAY  = 4'h8;
  localparam logic [3:0] OFF_MON   = 4'h9;
  localparam logic [3:0] OFF_YEAR  = 4'hA;
  localparam logic [3:0] OFF_RATE  = 4'hB;
  localparam logic [3:0] OFF_IEN   = 4'hC;
  localparam logic [3:0] OFF_FLAG  = 4'hD;
  localparam logic [3:0] OFF_CTRL  = 4'hE;

  localparam int IEN_HEART  = 1;  // heartbeat enable bit in OFF_IEN
  localparam int FLAG_HEART = 1;  // heartbeat flag bit in OFF_FLAG
  localparam int CTRL_H24   = 1;  // 1 = 24-hour form
  localparam int CTRL_STOP  = 2;  // 1 = clock frozen

  localparam int STORE_SLOTS = 4; // odd slots 1h,3h,5h,7h

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] day;
    logic [7:0] wday;
    logic [7:0] mon;
    logic [7:0] year;
  } timeRegs_t;

  localparam timeRegs_t TIME_AT_RESET = '{
    sec: 8'h00, min: 8'h00, hour: 8'h00, day: 8'h01,
    wday: 8'h01, mon: 8'h01, year: 8'h00};

  // Strobes from the control side to the time datapath.
  typedef struct packed {
    logic       secStep;
    logic       wrTime;
    logic [3:0] wrSel;
    logic [7:0] wrVal;
    logic       mode24;
  } dpCtl_t;

  function automatic logic [7:0] bcdInc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Value mod 4 of a two-digit BCD number equals (2*tensParity + ones) mod 4.
  function automatic logic isLeapBcd(input logic [7:0] y);
    logic [3:0] s;
    s = {2'b00, y[4], 1'b0} + y[3:0];
    return (s[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] monthLen(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return isLeapBcd(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int RATE_CODES    = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       cs,
  input  logic       rd,
  input  logic       wr,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  input  timeRegs_t  timeNow,
  output dpCtl_t     dpCtl,
  output logic [7:0] rdata,
  output logic       irqN
);

  localparam int DIV_W  = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam int PER_W  = RATE_CODES - 1;
  localparam int RATE_W = $clog2(RATE_CODES + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICKS_PER_SEC - 1);

  logic [DIV_W-1:0] divCnt;
  logic [PER_W-1:0] perCnt;
  logic [PER_W-1:0] perMask;
  logic [7:0]       rateReg, ienReg, ctrlReg;
  logic [8*STORE_SLOTS-1:0] storeFlat;
  logic             heartFlag;
  logic             stopped, secStep, perEvent, wrHit, rdHit, flagRead;
  logic [RATE_W-1:0] rateCode;
  logic [7:0]       rdNext;

  assign stopped  = ctrlReg[CTRL_STOP];
  assign wrHit    = cs & wr;
  assign rdHit    = cs & rd;
  assign flagRead = rdHit && (addr == OFF_FLAG);
  assign rateCode = rateReg[RATE_W-1:0];

  // One-second prescaler, frozen while stopped.
  assign secStep = tickEn && !stopped && (divCnt == DIV_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    divCnt <= '0;
    else if (tickEn && !stopped)  divCnt <= secStep ? '0 : divCnt + 1'b1;
  end

  // Heartbeat divider runs on every timebase pulse regardless of stop.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       perCnt <= '0;
    else if (tickEn) perCnt <= perCnt + 1'b1;
  end

  always_comb begin
    for (int b = 0; b < PER_W; b++) perMask[b] = (rateCode > RATE_W'(b + 1));
  end

  assign perEvent = tickEn && (rateCode != '0) && ((perCnt & perMask) == perMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         heartFlag <= 1'b0;
    else if (perEvent) heartFlag <= 1'b1;
    else if (flagRead) heartFlag <= 1'b0;
  end

  assign irqN = !(heartFlag && ienReg[IEN_HEART]);

  // Configuration registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateReg <= 8'h00;
      ienReg  <= 8'h00;
      ctrlReg <= 8'h02;
    end else if (wrHit) begin
      case (addr)
        OFF_RATE: rateReg <= wdata;
        OFF_IEN:  ienReg  <= wdata;
        OFF_CTRL: ctrlReg <= wdata;
        default:  ;
      endcase
    end
  end

  // Storage-only bytes on the odd slots below 8h.
  for (genvar g = 0; g < STORE_SLOTS; g++) begin : gStore
    logic [7:0] slotQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  slotQ <= 8'h00;
      else if (wrHit && addr == 4'(2 * g + 1))    slotQ <= wdata;
    end
    assign storeFlat[g*8 +: 8] = slotQ;
  end

  // Strobes to the time datapath.
  always_comb begin
    dpCtl.secStep = secStep;
    dpCtl.wrTime  = wrHit && (addr inside {OFF_SEC, OFF_MIN, OFF_HOUR, OFF_DAY,
                                           OFF_WDAY, OFF_MON, OFF_YEAR});
    dpCtl.wrSel   = addr;
    dpCtl.wrVal   = wdata;
    dpCtl.mode24  = ctrlReg[CTRL_H24];
  end

  always_comb begin
    case (addr)
      OFF_SEC:  rdNext = timeNow.sec;
      4'h1:     rdNext = storeFlat[7:0];
      OFF_MIN:  rdNext = timeNow.min;
      4'h3:     rdNext = storeFlat[15:8];
      OFF_HOUR: rdNext = timeNow.hour;
      4'h5:     rdNext = storeFlat[23:16];
      OFF_DAY:  rdNext = timeNow.day;
      4'h7:     rdNext = storeFlat[31:24];
      OFF_WDAY: rdNext = timeNow.wday;
      OFF_MON:  rdNext = timeNow.mon;
      OFF_YEAR: rdNext = timeNow.year;
      OFF_RATE: rdNext = rateReg;
      OFF_IEN:  rdNext = ienReg;
      OFF_FLAG: rdNext = 8'(heartFlag) << FLAG_HEART;
      OFF_CTRL: rdNext = ctrlReg;
      default:  rdNext = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      rdata <= 8'h00;
    else if (rdHit) rdata <= rdNext;
  end

  // R9: a flag read without a coincident event leaves the flag clear.
  a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rstN)
    flagRead && !perEvent |=> !heartFlag);

  // R8: rate code 0 never raises the flag.
  a_r8_rate0_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (rateCode == '0) && !heartFlag && !(wrHit && addr == OFF_RATE) |=> !heartFlag);

  // R7: prescaler holds while stopped.
  a_r7_div_frozen: assert property (@(posedge clk) disable iff (!rstN)
    stopped |=> $stable(divCnt));

  // R10: the interrupt line only falls after an event or an enable write.
  a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqN) |-> $past(perEvent) || $past(wrHit && addr == OFF_IEN));

endmodule

// File: rtl/rtc_time_dp.sv
module rtc_time_dp
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  dpCtl_t    dpCtl,
  output timeRegs_t timeNow
);

  timeRegs_t cur, nxt;
  logic minStep, hourStep, dayStep, monStep, yearStep;
  logic [4:0] hr12;
  logic       pmNow;
  logic [7:0] hrInc;

  always_comb begin
    nxt      = cur;
    hr12     = cur.hour[4:0];
    pmNow    = cur.hour[7];
    hrInc    = bcdInc({3'b000, hr12});
    minStep  = dpCtl.secStep && (cur.sec == 8'h59);
    hourStep = minStep && (cur.min == 8'h59);
    if (dpCtl.mode24) dayStep = hourStep && (cur.hour == 8'h23);
    else              dayStep = hourStep && (hr12 == 5'h11) && pmNow;
    monStep  = dayStep && (cur.day == monthLen(cur.mon, cur.year));
    yearStep = monStep && (cur.mon == 8'h12);

    if (dpCtl.secStep) nxt.sec = minStep ? 8'h00 : bcdInc(cur.sec);
    if (minStep)       nxt.min = hourStep ? 8'h00 : bcdInc(cur.min);
    if (hourStep) begin
      if (dpCtl.mode24)        nxt.hour = dayStep ? 8'h00 : bcdInc(cur.hour);
      else if (hr12 == 5'h12)  nxt.hour = {pmNow, 7'h01};
      else if (hr12 == 5'h11)  nxt.hour = {~pmNow, 7'h12};
      else                     nxt.hour = {pmNow, 2'b00, hrInc[4:0]};
    end
    if (dayStep) begin
      nxt.day  = monStep ? 8'h01 : bcdInc(cur.day);
      nxt.wday = (cur.wday == 8'h07) ? 8'h01 : cur.wday + 8'h01;
    end
    if (monStep)  nxt.mon  = yearStep ? 8'h01 : bcdInc(cur.mon);
    if (yearStep) nxt.year = (cur.year == 8'h99) ? 8'h00 : bcdInc(cur.year);

    // A bus write overrides the stepped value of the field it addresses.
    if (dpCtl.wrTime) begin
      case (dpCtl.wrSel)
        OFF_SEC:  nxt.sec  = dpCtl.wrVal;
        OFF_MIN:  nxt.min  = dpCtl.wrVal;
        OFF_HOUR: nxt.hour = dpCtl.wrVal;
        OFF_DAY:  nxt.day  = dpCtl.wrVal;
        OFF_WDAY: nxt.wday = dpCtl.wrVal;
        OFF_MON:  nxt.mon  = dpCtl.wrVal;
        OFF_YEAR: nxt.year = dpCtl.wrVal;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cur <= TIME_AT_RESET;
    else       cur <= nxt;
  end

  assign timeNow = cur;

  // R2: seconds wrap to zero on a step from 59.
  a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.secStep && (cur.sec == 8'h59) && !dpCtl.wrTime |=> cur.sec == 8'h00);

  // R7: with no step and no write, every time field holds.
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtl.secStep && !dpCtl.wrTime |=> $stable(cur));

  // R6: weekday returns to 1 after 7 on a date change.
  a_r6_wday_wrap: assert property (@(posedge clk) disable iff (!rstN)
    dayStep && (cur.wday == 8'h07) && !dpCtl.wrTime |=> cur.wday == 8'h01);

  // R4: in 12-hour form the PM marker inverts on the 11-to-12 step.
  a_r4_pm_toggle: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtl.mode24 && hourStep && (hr12 == 5'h11) && !dpCtl.wrTime
    |=> (cur.hour[4:0] == 5'h12) && (cur.hour[7] != $past(cur.hour[7])));

endmodule

// File: rtl/rtc_heartbeat.sv
module rtc_heartbeat
  import rtc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int RATE_CODES    = 15
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       cs,
  input  logic       rd,
  input  logic       wr,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irqN
);

  dpCtl_t    dpCtl;
  timeRegs_t timeNow;

  rtc_ctrl #(
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .RATE_CODES    (RATE_CODES)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .cs      (cs),
    .rd      (rd),
    .wr      (wr),
    .addr    (addr),
    .wdata   (wdata),
    .timeNow (timeNow),
    .dpCtl   (dpCtl),
    .rdata   (rdata),
    .irqN    (irqN)
  );

  rtc_time_dp uTime (
    .clk     (clk),
    .rstN    (rstN),
    .dpCtl   (dpCtl),
    .timeNow (timeNow)
  );

endmodule

// File: tb/sim_rtc_heartbeat.sv
module sim_rtc_heartbeat;

  localparam int TPS = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irqN;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  // Bench calendar model, binary fields.
  int mSec, mMin, mHr, mDay, mMon, mYr, mWday, phase;
  bit m24, mStop;

  always #5 clk = ~clk;

  rtc_heartbeat #(.TICKS_PER_SEC(TPS)) u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cs(cs), .rd(rd), .wr(wr),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irqN(irqN));

  function automatic logic [7:0] toBcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int lenOf(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] hourCode(input int h, input bit is24);
    int h12;
    if (is24) return toBcd(h);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return {(h >= 12), 2'b00, toBcd(h12)[4:0]};
  endfunction

  function automatic void stepSecond();
    mSec++;
    if (mSec < 60) return;
    mSec = 0; mMin++;
    if (mMin < 60) return;
    mMin = 0; mHr++;
    if (mHr < 24) return;
    mHr = 0;
    mWday = (mWday == 7) ? 1 : mWday + 1;
    mDay++;
    if (mDay <= lenOf(mMon, mYr)) return;
    mDay = 1; mMon++;
    if (mMon <= 12) return;
    mMon = 1; mYr = (mYr + 1) % 100;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); cs = 1'b0; wr = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1'b1; rd = 1'b1; addr = a;
    @(negedge clk); cs = 1'b0; rd = 1'b0;
    d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
      if (!mStop) begin
        phase++;
        if (phase == TPS) begin phase = 0; stepSecond(); end
      end
    end
  endtask

  task automatic setCtrl(input bit is24, input bit stop);
    m24 = is24; mStop = stop;
    busWrite(4'hE, {5'b0, stop, is24, 1'b0});
  endtask

  task automatic loadTime();
    busWrite(4'h0, toBcd(mSec));
    busWrite(4'h2, toBcd(mMin));
    busWrite(4'h4, hourCode(mHr, m24));
    busWrite(4'h6, toBcd(mDay));
    busWrite(4'h8, toBcd(mWday));
    busWrite(4'h9, toBcd(mMon));
    busWrite(4'hA, toBcd(mYr));
  endtask

  task automatic checkTime(input string tag);
    logic [7:0] v;
    busRead(4'h0, v); chk({"R2 sec ", tag}, v, toBcd(mSec));
    busRead(4'h2, v); chk({"R2 min ", tag}, v, toBcd(mMin));
    busRead(4'h4, v); chk(m24 ? {"R3 hour ", tag} : {"R4 hour ", tag}, v, hourCode(mHr, m24));
    busRead(4'h6, v); chk({"R5 day ", tag}, v, toBcd(mDay));
    busRead(4'h8, v); chk({"R6 wday ", tag}, v, toBcd(mWday));
    busRead(4'h9, v); chk({"R6 month ", tag}, v, toBcd(mMon));
    busRead(4'hA, v); chk({"R6 year ", tag}, v, toBcd(mYr));
  endtask

  task automatic setModel(input int yr, input int mo, input int dy, input int wd,
                          input int hr, input int mi, input int se);
    mYr = yr; mMon = mo; mDay = dy; mWday = wd; mHr = hr; mMin = mi; mSec = se;
  endtask

  initial begin
    logic [7:0] v;
    int n;
    void'($urandom(32'd20240611));
    setModel(0, 1, 1, 1, 0, 0, 0);
    m24 = 1'b1; mStop = 1'b0; phase = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 / R12: reset state read through the registered read path
    chk("R1 irqN", {7'b0, irqN}, 8'h01);
    busRead(4'hE, v); chk("R1 ctrl (R12 read)", v, 8'h02);
    busRead(4'hB, v); chk("R1 rate", v, 8'h00);
    busRead(4'hC, v); chk("R1 enable", v, 8'h00);
    checkTime("reset R1");
    busRead(4'h2, v);
    @(negedge clk); chk("R12 rdata holds", rdata, 8'h00);

    // R2: a full second needs TPS pulses
    ticks(TPS - 1); checkTime("before first step");
    ticks(1);       checkTime("first step");

    // R6: end of century rollover
    setModel(99, 12, 31, 7, 23, 59, 59); loadTime();
    ticks(TPS); checkTime("century");

    // R5: leap and non-leap February end
    setModel(4, 2, 28, 3, 23, 59, 59); loadTime();
    ticks(TPS); checkTime("leap 28");
    setModel(4, 2, 29, 4, 23, 59, 59); loadTime();
    ticks(TPS); checkTime("leap 29");
    setModel(5, 2, 28, 2, 23, 59, 59); loadTime();
    ticks(TPS); checkTime("plain feb");
    setModel(21, 4, 30, 5, 23, 59, 59); loadTime();
    ticks(TPS); checkTime("30-day month");

    // R4: 12-hour form at noon and midnight
    setCtrl(1'b0, 1'b0);
    setModel(10, 6, 15, 2, 11, 59, 59); loadTime();
    ticks(TPS); checkTime("noon");
    ticks(TPS * 3600); checkTime("one pm");
    setModel(10, 6, 15, 2, 23, 59, 59); loadTime();
    ticks(TPS); checkTime("midnight 12h");
    setCtrl(1'b1, 1'b0); loadTime();

    // R7: stop freezes time, writes still land
    setCtrl(1'b1, 1'b1);
    ticks(3 * TPS); checkTime("stopped");
    busWrite(4'h0, 8'h30); mSec = 30;
    busRead(4'h0, v); chk("R7 write while stopped", v, 8'h30);
    setCtrl(1'b1, 1'b0);
    ticks(2 * TPS); checkTime("resumed");

    // R11: storage-only bytes, read-only flags, empty slot
    busWrite(4'h1, 8'h5A); busRead(4'h1, v); chk("R11 slot 1h", v, 8'h5A);
    busWrite(4'h7, 8'hC3); busRead(4'h7, v); chk("R11 slot 7h", v, 8'hC3);
    busWrite(4'hF, 8'hFF); busRead(4'hF, v); chk("R11 slot Fh", v, 8'h00);
    busWrite(4'hB, 8'hA0); busWrite(4'hC, 8'h00);
    busRead(4'hD, v);
    busWrite(4'hD, 8'hFF); busRead(4'hD, v); chk("R11 flags not writable", v, 8'h00);
    ticks(20); busRead(4'hD, v); chk("R11 watchdog nibble inert / R8 code 0", v, 8'h00);
    busWrite(4'hE, 8'h0B); m24 = 1'b1;
    ticks(TPS); checkTime("stored ctrl bits");
    busRead(4'hE, v); chk("R11 ctrl readback", v, 8'h0B);
    setCtrl(1'b1, 1'b0);

    // R8 / R9 / R10: heartbeat with period 4 pulses (code 3)
    busWrite(4'hC, 8'h02); busWrite(4'hB, 8'h03);
    busRead(4'hD, v);
    n = 0;
    for (int i = 0; i < 8 && irqN; i++) begin ticks(1); n++; end
    chk("R10 irq falls", {7'b0, irqN}, 8'h00);
    chk("R8 first event within period", 8'(n <= 4), 8'h01);
    busRead(4'hD, v); chk("R9 flag read", v, 8'h02);
    chk("R9 irq released", {7'b0, irqN}, 8'h01);
    busRead(4'hD, v); chk("R9 flag cleared", v, 8'h00);
    ticks(3); chk("R8 no early event", {7'b0, irqN}, 8'h01);
    ticks(1); chk("R8 event on period", {7'b0, irqN}, 8'h00);
    busRead(4'hD, v);
    busWrite(4'hC, 8'h00);
    ticks(4); chk("R10 masked", {7'b0, irqN}, 8'h01);
    busRead(4'hD, v); chk("R10 flag set while masked", v, 8'h02);
    busWrite(4'hB, 8'h01); busRead(4'hD, v);
    ticks(1); busRead(4'hD, v); chk("R8 code 1 each pulse", v, 8'h02);
    busWrite(4'hB, 8'h00); busRead(4'hD, v);
    ticks(40); busRead(4'hD, v); chk("R8 code 0 silent", v, 8'h00);

    // Random starting dates, both hour forms, biased toward wraps
    for (int it = 0; it < 30; it++) begin
      setCtrl(1'($urandom % 2), 1'b0);
      mYr  = $urandom % 100;
      mMon = 1 + $urandom % 12;
      mDay = ($urandom % 2) ? lenOf(mMon, mYr) : 1 + $urandom % lenOf(mMon, mYr);
      mWday = 1 + $urandom % 7;
      mHr  = ($urandom % 2) ? (($urandom % 2) ? 23 : 11) : $urandom % 24;
      mMin = 55 + $urandom % 5;
      mSec = 50 + $urandom % 10;
      loadTime();
      ticks($urandom % (12 * TPS));
      checkTime("random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule